// File: doc/BRIEF.md
# Epoch-Based Page Migration Planner

This block decides, once per fixed-length epoch, which pages should move between the memory slices of a small set of memory controllers. At every epoch boundary it takes a snapshot of each controller's row-buffer hit rate and of its page-conflict count. A controller whose hit rate has dropped by at least a programmable percentage since the previous snapshot is marked as a donor that must shed pages.

Donors are served one after another, in ascending index order. For each donor the block chooses a receiving controller by the smallest weighted sum of hop distance and last-epoch conflict count. Controllers that are donors themselves are never chosen. The block then pulls candidate pages, least recently used first, from an external supplier over a valid/ready handshake. It emits one migration command per accepted page until a fixed page quota is reached or the supplier runs dry. Every page it moves is held in a small cooldown table so that the page is not moved again during the next two epochs.

The page copy, the translation and cache clean-up that follow, and the recency structure that supplies candidates all sit outside this block.

Top module: `pgmig_planner`

## Requirements
- R1: `epoch_tick_o` is high for exactly one cycle in every `EPOCH_CYCLES` cycles. The first pulse comes `EPOCH_CYCLES` cycles after reset is released. In a tick cycle `cand_ready_o` is low.
- R2: At a tick the block samples `hit_rate_i` (unsigned, slice c at bits `c*RATE_W`) and `drop_pct_i` (a whole percentage). Controller c becomes a donor when cur < prev and (prev − cur)·100 ≥ pct·prev, where prev is the rate sampled at the tick before. A drop of exactly the threshold qualifies, and a smaller drop does not.
- R3: In the epoch that follows the first tick after reset there is no earlier snapshot to compare against, so no migration is issued.
- R4: The recipient for donor d is the controller k that is not a donor and has the smallest LAMBDA·dist(d,k) + GAMMA·conf(k). Here dist is slice `(d*NUM_CTRL+k)` of `hop_dist_i`, and conf is the value of `conflict_i` sampled at the tick. On equal cost the lower index wins.
- R5: For each donor the block accepts candidates in the order the supplier offers them. It issues at most `PAGES_PER_DONOR` migrations, and it stops early when `cand_empty_i` is high while it is asking for a page. Each migration is a one-cycle `mig_valid_o` pulse, in the cycle after the accept, that carries the page, the donor (`mig_src_o`) and the recipient (`mig_dst_o`).
- R6: A page migrated in epoch E is accepted but not migrated in epochs E, E+1 and E+2; the next candidate is taken instead. From epoch E+3 the page can be migrated again.
- R7: When several controllers are donors, all migrations of a lower-index donor come before those of any higher-index donor. `cand_ctrl_o` names the donor being served.
- R8: When every controller is a donor, no migration is issued in that epoch.
- R9: During and just after reset, `mig_valid_o`, `cand_ready_o` and `epoch_tick_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_rate_i | input | NUM_CTRL*RATE_W | Per-controller row-buffer hit rate |
| conflict_i | input | NUM_CTRL*CONF_W | Per-controller page-conflict count of the ending epoch |
| hop_dist_i | input | NUM_CTRL*NUM_CTRL*DIST_W | Hop distance matrix, entry (d,k) at slice d*NUM_CTRL+k |
| drop_pct_i | input | PCT_W | Donor threshold in percent |
| cand_valid_i | input | 1 | Supplier offers a candidate page |
| cand_empty_i | input | 1 | Supplier has no further page for `cand_ctrl_o` |
| cand_page_i | input | PAGE_W | Offered page identifier |
| epoch_tick_o | output | 1 | Epoch boundary pulse |
| cand_ready_o | output | 1 | Planner takes the offered candidate |
| cand_ctrl_o | output | CTRL_W | Donor whose candidates are requested |
| mig_valid_o | output | 1 | Migration command pulse |
| mig_page_o | output | PAGE_W | Page to migrate |
| mig_src_o | output | CTRL_W | Donor controller |
| mig_dst_o | output | CTRL_W | Recipient controller |

## Verification
The properties assume the supplier never raises `cand_valid_i` and `cand_empty_i` together. They also assume it keeps offering candidates for whatever controller `cand_ctrl_o` names, and that an epoch is long enough for all donors to be served before the next tick. The bench's supplier model resets its per-controller list pointers at each boundary and derives valid and empty from a single pointer comparison, so the two are exclusive. It uses a 64-cycle epoch, within which three donors with skipped pages finish with room to spare.

// File: rtl/pgmig_pkg.sv
package pgmig_pkg;
   typedef enum logic [1:0] {
      PL_IDLE  = 2'd0,
      PL_LOAD  = 2'd1,
      PL_PICK  = 2'd2,
      PL_FETCH = 2'd3
   } plan_state_e;
endpackage

// File: rtl/pgmig_epoch_timer.sv
module pgmig_epoch_timer #(
   parameter int EPOCH_CYCLES = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = (EPOCH_CYCLES > 2) ? $clog2(EPOCH_CYCLES) : 1;

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == CNT_W'(EPOCH_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pgmig_donor_detect.sv
module pgmig_donor_detect #(
   parameter int NUM_CTRL = 4,
   parameter int RATE_W   = 10,
   parameter int PCT_W    = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       snap_i,
   input  logic [NUM_CTRL*RATE_W-1:0] rate_i,
   input  logic [PCT_W-1:0]           pct_i,
   output logic [NUM_CTRL-1:0]        donor_o
);
   localparam int MUL_W  = (PCT_W > 7) ? PCT_W : 7;
   localparam int PROD_W = RATE_W + MUL_W + 1;

   logic [RATE_W-1:0] cur_q  [NUM_CTRL];
   logic [RATE_W-1:0] prev_q [NUM_CTRL];
   logic [PCT_W-1:0]  pct_q;
   logic [1:0]        fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CTRL; i++) begin
            cur_q[i]  <= '0;
            prev_q[i] <= '0;
         end
         pct_q  <= '0;
         fill_q <= '0;
      end else if (snap_i) begin
         for (int i = 0; i < NUM_CTRL; i++) begin
            prev_q[i] <= cur_q[i];
            cur_q[i]  <= rate_i[i*RATE_W +: RATE_W];
         end
         pct_q <= pct_i;
         if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
      end
   end

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
      logic [RATE_W-1:0] diff;
      logic [PROD_W-1:0] fall_scaled;
      logic [PROD_W-1:0] limit;
      assign diff        = prev_q[g] - cur_q[g];
      assign fall_scaled = PROD_W'(diff) * PROD_W'(100);
      assign limit       = PROD_W'(pct_q) * PROD_W'(prev_q[g]);
      assign donor_o[g]  = (fill_q == 2'd2) && (cur_q[g] < prev_q[g])
                           && (fall_scaled >= limit);
   end
endmodule

// File: rtl/pgmig_recipient_sel.sv
module pgmig_recipient_sel #(
   parameter int NUM_CTRL = 4,
   parameter int CONF_W   = 16,
   parameter int DIST_W   = 4,
   parameter int LAMBDA   = 100,
   parameter int GAMMA    = 100,
   parameter int CTRL_W   = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                snap_i,
   input  logic [NUM_CTRL*CONF_W-1:0]          conf_i,
   input  logic [NUM_CTRL*NUM_CTRL*DIST_W-1:0] dist_i,
   input  logic [NUM_CTRL-1:0]                 donor_mask_i,
   input  logic [CTRL_W-1:0]                   donor_idx_i,
   output logic                                found_o,
   output logic [CTRL_W-1:0]                   dst_o
);
   localparam int COST_W = $clog2(LAMBDA + 1) + DIST_W + $clog2(GAMMA + 1) + CONF_W + 1;

   logic [CONF_W-1:0] conf_q [NUM_CTRL];
   logic [DIST_W-1:0] row    [NUM_CTRL];
   logic [COST_W-1:0] cost   [NUM_CTRL];
   logic [NUM_CTRL-1:0] eligible;
   logic [COST_W-1:0] best;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CTRL; i++) conf_q[i] <= '0;
      end else if (snap_i) begin
         for (int i = 0; i < NUM_CTRL; i++) conf_q[i] <= conf_i[i*CONF_W +: CONF_W];
      end
   end

   always_comb begin
      for (int k = 0; k < NUM_CTRL; k++) row[k] = '0;
      for (int d = 0; d < NUM_CTRL; d++) begin
         if (CTRL_W'(d) == donor_idx_i) begin
            for (int k = 0; k < NUM_CTRL; k++)
               row[k] = dist_i[(d*NUM_CTRL + k)*DIST_W +: DIST_W];
         end
      end
   end

   for (genvar k = 0; k < NUM_CTRL; k++) begin : g_cost
      assign cost[k] = COST_W'(LAMBDA) * COST_W'(row[k])
                     + COST_W'(GAMMA)  * COST_W'(conf_q[k]);
      assign eligible[k] = !donor_mask_i[k] && (CTRL_W'(k) != donor_idx_i);
   end

   always_comb begin
      found_o = 1'b0;
      dst_o   = '0;
      best    = '0;
      for (int k = 0; k < NUM_CTRL; k++) begin
         if (eligible[k] && (!found_o || cost[k] < best)) begin
            found_o = 1'b1;
            dst_o   = CTRL_W'(k);
            best    = cost[k];
         end
      end
   end
endmodule

// File: rtl/pgmig_cooldown_cam.sv
module pgmig_cooldown_cam #(
   parameter int DEPTH       = 96,
   parameter int PAGE_W      = 20,
   parameter int COOL_EPOCHS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              epoch_adv_i,
   input  logic [PAGE_W-1:0] look_page_i,
   output logic              hit_o,
   input  logic              ins_i,
   input  logic [PAGE_W-1:0] ins_page_i
);
   localparam int EP_W  = $clog2(COOL_EPOCHS + 2) + 1;
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]  vld_q;
   logic [DEPTH-1:0]  match;
   logic [DEPTH-1:0]  stale;
   logic [PAGE_W-1:0] page_q [DEPTH];
   logic [EP_W-1:0]   tag_q  [DEPTH];
   logic [EP_W-1:0]   ep_q;
   logic              slot_ok;
   logic [IDX_W-1:0]  slot;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [EP_W-1:0] age_next;
      assign age_next = ep_q + 1'b1 - tag_q[g];
      assign match[g] = vld_q[g] && (page_q[g] == look_page_i);
      assign stale[g] = age_next > EP_W'(COOL_EPOCHS);
   end

   assign hit_o = |match;

   always_comb begin
      slot_ok = 1'b0;
      slot    = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            slot_ok = 1'b1;
            slot    = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ep_q  <= '0;
      end else begin
         if (epoch_adv_i) begin
            ep_q <= ep_q + 1'b1;
            for (int i = 0; i < DEPTH; i++)
               if (stale[i]) vld_q[i] <= 1'b0;
         end
         if (ins_i && slot_ok) vld_q[slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_i && slot_ok) begin
         page_q[slot] <= ins_page_i;
         tag_q[slot]  <= ep_q;
      end
   end
endmodule

// File: rtl/pgmig_planner.sv
module pgmig_planner #(
   parameter int NUM_CTRL        = 4,
   parameter int EPOCH_CYCLES    = 5_000_000,
   parameter int RATE_W          = 10,
   parameter int CONF_W          = 16,
   parameter int DIST_W          = 4,
   parameter int PCT_W           = 7,
   parameter int PAGE_W          = 20,
   parameter int LAMBDA          = 100,
   parameter int GAMMA           = 100,
   parameter int PAGES_PER_DONOR = 10,
   parameter int COOL_EPOCHS     = 2,
   parameter int CAM_DEPTH       = 96,
   localparam int CTRL_W         = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CTRL*RATE_W-1:0]          hit_rate_i,
   input  logic [NUM_CTRL*CONF_W-1:0]          conflict_i,
   input  logic [NUM_CTRL*NUM_CTRL*DIST_W-1:0] hop_dist_i,
   input  logic [PCT_W-1:0]                    drop_pct_i,
   input  logic                                cand_valid_i,
   input  logic                                cand_empty_i,
   input  logic [PAGE_W-1:0]                   cand_page_i,
   output logic                                epoch_tick_o,
   output logic                                cand_ready_o,
   output logic [CTRL_W-1:0]                   cand_ctrl_o,
   output logic                                mig_valid_o,
   output logic [PAGE_W-1:0]                   mig_page_o,
   output logic [CTRL_W-1:0]                   mig_src_o,
   output logic [CTRL_W-1:0]                   mig_dst_o
);
   import pgmig_pkg::*;

   localparam int CNT_W    = $clog2(PAGES_PER_DONOR + 1);
   localparam int CAM_NEED = (NUM_CTRL - 1) * PAGES_PER_DONOR * (COOL_EPOCHS + 1);

   if (NUM_CTRL < 2) begin : g_bad_ctrl
      $error("pgmig_planner: NUM_CTRL must be at least 2");
   end
   if (PAGES_PER_DONOR < 1) begin : g_bad_quota
      $error("pgmig_planner: PAGES_PER_DONOR must be at least 1");
   end
   if (CAM_DEPTH < CAM_NEED) begin : g_bad_cam
      $error("pgmig_planner: CAM_DEPTH too small for the cooldown window");
   end
   if (EPOCH_CYCLES < 8) begin : g_bad_epoch
      $error("pgmig_planner: EPOCH_CYCLES too short");
   end

   plan_state_e         state_q;
   logic [NUM_CTRL-1:0] donor_mask;
   logic [NUM_CTRL-1:0] pend_q;
   logic [CTRL_W-1:0]   low_idx;
   logic                low_any;
   logic                rcpt_found;
   logic [CTRL_W-1:0]   rcpt_idx;
   logic [CTRL_W-1:0]   donor_q;
   logic [CTRL_W-1:0]   dst_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                locked;
   logic                take;
   logic                mig_v_q;
   logic [PAGE_W-1:0]   mig_page_q;
   logic [CTRL_W-1:0]   mig_src_q;
   logic [CTRL_W-1:0]   mig_dst_q;

   pgmig_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (epoch_tick_o)
   );

   pgmig_donor_detect #(
      .NUM_CTRL (NUM_CTRL),
      .RATE_W   (RATE_W),
      .PCT_W    (PCT_W)
   ) u_donor (
      .clk     (clk),
      .rst_n   (rst_n),
      .snap_i  (epoch_tick_o),
      .rate_i  (hit_rate_i),
      .pct_i   (drop_pct_i),
      .donor_o (donor_mask)
   );

   always_comb begin
      low_idx = '0;
      low_any = 1'b0;
      for (int i = NUM_CTRL - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            low_idx = CTRL_W'(i);
            low_any = 1'b1;
         end
      end
   end

   pgmig_recipient_sel #(
      .NUM_CTRL (NUM_CTRL),
      .CONF_W   (CONF_W),
      .DIST_W   (DIST_W),
      .LAMBDA   (LAMBDA),
      .GAMMA    (GAMMA),
      .CTRL_W   (CTRL_W)
   ) u_rcpt (
      .clk          (clk),
      .rst_n        (rst_n),
      .snap_i       (epoch_tick_o),
      .conf_i       (conflict_i),
      .dist_i       (hop_dist_i),
      .donor_mask_i (donor_mask),
      .donor_idx_i  (low_idx),
      .found_o      (rcpt_found),
      .dst_o        (rcpt_idx)
   );

   assign cand_ready_o = (state_q == PL_FETCH) && !epoch_tick_o;
   assign cand_ctrl_o  = donor_q;
   assign take         = cand_ready_o && cand_valid_i && !cand_empty_i && !locked;

   pgmig_cooldown_cam #(
      .DEPTH       (CAM_DEPTH),
      .PAGE_W      (PAGE_W),
      .COOL_EPOCHS (COOL_EPOCHS)
   ) u_cool (
      .clk         (clk),
      .rst_n       (rst_n),
      .epoch_adv_i (epoch_tick_o),
      .look_page_i (cand_page_i),
      .hit_o       (locked),
      .ins_i       (take),
      .ins_page_i  (cand_page_i)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PL_IDLE;
         pend_q  <= '0;
         donor_q <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         mig_v_q <= 1'b0;
      end else begin
         mig_v_q <= 1'b0;
         if (epoch_tick_o) begin
            state_q <= PL_LOAD;
            pend_q  <= '0;
         end else begin
            unique case (state_q)
               PL_IDLE: ;
               PL_LOAD: begin
                  pend_q  <= donor_mask;
                  state_q <= PL_PICK;
               end
               PL_PICK: begin
                  if (!low_any || !rcpt_found) begin
                     pend_q  <= '0;
                     state_q <= PL_IDLE;
                  end else begin
                     donor_q <= low_idx;
                     dst_q   <= rcpt_idx;
                     cnt_q   <= '0;
                     state_q <= PL_FETCH;
                  end
               end
               PL_FETCH: begin
                  if (cand_empty_i) begin
                     pend_q[donor_q] <= 1'b0;
                     state_q         <= PL_PICK;
                  end else if (take) begin
                     mig_v_q <= 1'b1;
                     if (cnt_q == CNT_W'(PAGES_PER_DONOR - 1)) begin
                        pend_q[donor_q] <= 1'b0;
                        state_q         <= PL_PICK;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               default: state_q <= PL_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         mig_page_q <= cand_page_i;
         mig_src_q  <= donor_q;
         mig_dst_q  <= dst_q;
      end
   end

   assign mig_valid_o = mig_v_q;
   assign mig_page_o  = mig_page_q;
   assign mig_src_o   = mig_src_q;
   assign mig_dst_o   = mig_dst_q;
endmodule

// File: rtl/pgmig_planner_chk.sv
module pgmig_planner_chk #(
   parameter int NUM_CTRL        = 4,
   parameter int PAGES_PER_DONOR = 10,
   parameter int CTRL_W          = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              epoch_tick_o,
   input logic              cand_valid_i,
   input logic              cand_ready_o,
   input logic [CTRL_W-1:0] cand_ctrl_o,
   input logic              mig_valid_o,
   input logic [CTRL_W-1:0] mig_src_o,
   input logic [CTRL_W-1:0] mig_dst_o
);
   localparam int LIMIT = (NUM_CTRL - 1) * PAGES_PER_DONOR;
   localparam int CW    = $clog2(LIMIT + 2);

   logic [1:0]    ticks_q;
   logic [CW-1:0] per_epoch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ticks_q     <= '0;
         per_epoch_q <= '0;
      end else begin
         if (epoch_tick_o && ticks_q != 2'd2) ticks_q <= ticks_q + 2'd1;
         if (epoch_tick_o)     per_epoch_q <= '0;
         else if (mig_valid_o) per_epoch_q <= per_epoch_q + 1'b1;
      end
   end

   // R1
   tick_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      epoch_tick_o |-> !cand_ready_o);

   // R3
   no_first_epoch_mig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ticks_q != 2'd2) |-> !mig_valid_o);

   // R4
   src_not_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mig_valid_o |-> (mig_src_o != mig_dst_o));

   // R5
   mig_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mig_valid_o |-> $past(cand_valid_i && cand_ready_o));

   // R5
   epoch_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mig_valid_o |-> (per_epoch_q < CW'(LIMIT)));

   // R7
   donor_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_ready_o && $past(cand_ready_o)) |-> $stable(cand_ctrl_o));
endmodule

bind pgmig_planner pgmig_planner_chk #(
   .NUM_CTRL        (NUM_CTRL),
   .PAGES_PER_DONOR (PAGES_PER_DONOR),
   .CTRL_W          (CTRL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .epoch_tick_o (epoch_tick_o),
   .cand_valid_i (cand_valid_i),
   .cand_ready_o (cand_ready_o),
   .cand_ctrl_o  (cand_ctrl_o),
   .mig_valid_o  (mig_valid_o),
   .mig_src_o    (mig_src_o),
   .mig_dst_o    (mig_dst_o)
);

// File: tb/pgmig_planner_tb.sv
module pgmig_planner_tb;
   localparam int NC = 4;
   localparam int EP = 64;
   localparam int RW = 10;
   localparam int CFW = 16;
   localparam int DW = 4;
   localparam int PW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC*RW-1:0]    hit_rate;
   logic [NC*CFW-1:0]   conflict;
   logic [NC*NC*DW-1:0] hop_dist;
   logic [6:0]          drop_pct;
   logic                cand_valid, cand_empty;
   logic [PW-1:0]       cand_page;
   logic                tick, cand_ready, mig_valid;
   logic [1:0]          cand_ctrl, mig_src, mig_dst;
   logic [PW-1:0]       mig_page;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [PW-1:0] sup_list [NC][16];
   int sup_len [NC];
   int ptr [NC];

   int lg_n;
   logic [PW-1:0] lg_page [64];
   int lg_src [64];
   int lg_dst [64];
   int ex_n;
   logic [PW-1:0] ex_page [64];
   int ex_src [64];
   int ex_dst [64];

   always #2 clk = ~clk;

   pgmig_planner #(.EPOCH_CYCLES(EP)) u_dut (
      .clk(clk), .rst_n(rst_n), .hit_rate_i(hit_rate), .conflict_i(conflict),
      .hop_dist_i(hop_dist), .drop_pct_i(drop_pct), .cand_valid_i(cand_valid),
      .cand_empty_i(cand_empty), .cand_page_i(cand_page), .epoch_tick_o(tick),
      .cand_ready_o(cand_ready), .cand_ctrl_o(cand_ctrl), .mig_valid_o(mig_valid),
      .mig_page_o(mig_page), .mig_src_o(mig_src), .mig_dst_o(mig_dst));

   always_comb begin
      cand_valid = ptr[cand_ctrl] < sup_len[cand_ctrl];
      cand_empty = !cand_valid;
      cand_page  = sup_list[cand_ctrl][ptr[cand_ctrl] & 15];
   end

   always @(posedge clk)
      if (cand_ready && cand_valid) ptr[cand_ctrl] <= ptr[cand_ctrl] + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_inputs(input int r0, r1, r2, r3, input int c0, c1, c2, c3, input int pct);
      hit_rate = {RW'(r3), RW'(r2), RW'(r1), RW'(r0)};
      conflict = {CFW'(c3), CFW'(c2), CFW'(c1), CFW'(c0)};
      drop_pct = 7'(pct);
   endtask

   task automatic sup_fill(input int c, input int base, input int n);
      for (int i = 0; i < n; i++) sup_list[c][i] = PW'(base + i);
      sup_len[c] = n;
   endtask

   task automatic sup_clear();
      for (int c = 0; c < NC; c++) begin
         sup_len[c] = 0;
         ptr[c] = 0;
      end
   endtask

   task automatic exp_add(input int base, input int n, input int s, input int d);
      for (int i = 0; i < n; i++) begin
         ex_page[ex_n] = PW'(base + i);
         ex_src[ex_n] = s;
         ex_dst[ex_n] = d;
         ex_n++;
      end
   endtask

   // Called at the negedge where tick is high; collects the next epoch.
   task automatic run_epoch(input string req);
      int gap;
      gap = 0;
      lg_n = 0;
      for (int c = 0; c < NC; c++) ptr[c] = 0;
      do begin
         @(negedge clk);
         gap++;
         if (mig_valid && lg_n < 64) begin
            lg_page[lg_n] = mig_page;
            lg_src[lg_n] = int'(mig_src);
            lg_dst[lg_n] = int'(mig_dst);
            lg_n++;
         end
      end while (!tick);
      chk("R1 tick spacing", gap, EP);
      chk({req, " count"}, lg_n, ex_n);
      for (int i = 0; i < ex_n && i < lg_n; i++) begin
         chk({req, " page"}, int'(lg_page[i]), int'(ex_page[i]));
         chk({req, " src"}, lg_src[i], ex_src[i]);
         chk({req, " dst"}, lg_dst[i], ex_dst[i]);
      end
      ex_n = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 mig_valid in reset", int'(mig_valid), 0);
      chk("R9 cand_ready in reset", int'(cand_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 tick after reset", int'(tick), 0);
      chk("R9 mig_valid after reset", int'(mig_valid), 0);
      while (!tick) @(negedge clk);
   endtask

   task automatic t_first_epoch();
      set_inputs(500, 500, 500, 500, 5, 3, 9, 0, 10);
      sup_fill(1, 'h900, 12);
      run_epoch("R3 first epoch");
   endtask

   task automatic t_exact_drop();
      sup_clear();
      set_inputs(500, 450, 500, 500, 5, 3, 9, 0, 10);
      sup_fill(1, 'h100, 12);
      exp_add('h100, 10, 1, 3);
      run_epoch("R2 R4 R5 exact threshold");
   endtask

   task automatic t_small_drop();
      sup_clear();
      set_inputs(455, 450, 500, 500, 5, 3, 9, 0, 10);
      sup_fill(0, 'h700, 12);
      run_epoch("R2 below threshold");
   endtask

   task automatic t_cool_skip();
      sup_clear();
      set_inputs(455, 450, 450, 500, 5, 3, 9, 0, 10);
      sup_list[2][0] = PW'('h100);
      sup_list[2][1] = PW'('h101);
      for (int i = 0; i < 12; i++) sup_list[2][i+2] = PW'('h200 + i);
      sup_len[2] = 14;
      exp_add('h200, 10, 2, 3);
      run_epoch("R6 cooldown skip");
   endtask

   task automatic t_cool_expire();
      sup_clear();
      set_inputs(455, 405, 450, 500, 0, 3, 9, 9, 10);
      sup_list[1][0] = PW'('h100);
      sup_list[1][1] = PW'('h200);
      for (int i = 0; i < 12; i++) sup_list[1][i+2] = PW'('h300 + i);
      sup_len[1] = 14;
      exp_add('h100, 1, 1, 0);
      exp_add('h300, 9, 1, 0);
      run_epoch("R6 R4 cooldown expiry");
   endtask

   task automatic t_multi_donor();
      sup_clear();
      set_inputs(400, 405, 450, 450, 0, 2, 1, 0, 10);
      sup_fill(0, 'h400, 3);
      sup_fill(3, 'h500, 12);
      exp_add('h400, 3, 0, 1);
      exp_add('h500, 10, 3, 2);
      run_epoch("R7 R4 R5 two donors tie and early empty");
   endtask

   task automatic t_all_donors();
      sup_clear();
      set_inputs(100, 100, 100, 100, 0, 0, 0, 0, 10);
      for (int c = 0; c < NC; c++) sup_fill(c, 'hA00 + c*16, 12);
      run_epoch("R8 all donors");
   endtask

   task automatic t_prog_threshold();
      sup_clear();
      set_inputs(100, 60, 40, 100, 0, 0, 0, 0, 50);
      sup_fill(1, 'hB00, 12);
      sup_fill(2, 'h600, 12);
      exp_add('h600, 10, 2, 1);
      run_epoch("R2 R4 programmed threshold");
   endtask

   initial begin
      for (int d = 0; d < NC; d++)
         for (int k = 0; k < NC; k++)
            hop_dist[(d*NC+k)*DW +: DW] = DW'((d > k) ? d - k : k - d);
      ex_n = 0;
      sup_clear();
      set_inputs(500, 500, 500, 500, 0, 0, 0, 0, 10);
      t_reset();
      t_first_epoch();
      t_exact_drop();
      t_small_drop();
      t_cool_skip();
      t_cool_expire();
      t_multi_donor();
      t_all_donors();
      t_prog_threshold();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule